// File: doc/BRIEF.md
# Boundary-Tag Heap Allocator

This block manages a heap kept in a word-addressed, single-port RAM that sits outside it. The heap is an implicit chain of blocks. Each block begins with a header word and ends with a footer word. Both words carry the same tag: the block size in words, counting the header and footer, with bit 0 used as an in-use flag. Two fixed sentinel words bound the chain: one below the first block and one at the top of the heap. Both are tagged as in use.

An allocate command walks the chain from the lowest block and takes the first free block that is large enough. If that block is larger than needed, the engine cuts it in two. It then tags the block as in use and returns a payload pointer, or it reports failure. A free command takes a payload pointer. The engine reads three tags: the block's own header, the footer of the block below it, and the header of the block above it. It then joins the block with whichever neighbours are free, using exactly two RAM writes whichever of the four cases applies.

Commands use a valid/ready handshake. Each accepted command yields one single-cycle response. The RAM port has a read latency of one cycle.

Top module: `heap_alloc_top`

## Requirements
- R1: After reset the engine writes four words. Address 0 gets the lower sentinel (value 1). Address HEAP_WORDS-1 gets the upper sentinel (value 1). Addresses 1 and HEAP_WORDS-2 get the header and footer of one free block of size HEAP_WORDS-2. cmd_ready stays low during reset and until these writes finish, and no RAM access ever targets an address at or above HEAP_WORDS.
- R2: A tag word is ADDR_W bits wide. It holds an even block size that counts both boundary words. Bit 0 is 1 for a block in use and 0 for a free block, and the size is read with bit 0 forced to 0. A block's header and footer always hold the same tag.
- R3: An allocate command (cmd_op = 0) for s words needs a block of size s rounded up to even, plus 2. If s = 0, or if that size exceeds HEAP_WORDS-2, the engine reports failure without touching the RAM.
- R4: The search starts at the block at address 1 and steps from header to header by block size. It takes the first free block whose size is at least the needed size, even when a closer fit lies further on.
- R5: The chosen block is cut when the leftover is at least MIN_SPLIT (default 4) words. The in-use part is tagged with the needed size. The leftover becomes a free block with a header just above the in-use part and a footer in the old last word. A smaller leftover stays inside the block, and the whole block is tagged in use with its full size.
- R6: A successful allocation answers rsp_ok = 1 with rsp_ptr equal to the header address plus 1.
- R7: An allocation that reaches the upper sentinel without a fit answers rsp_ok = 0 and rsp_ptr = 0, and writes nothing.
- R8: A free command (cmd_op = 1, cmd_ptr = payload pointer) whose two neighbours are both in use keeps the block's size and clears bit 0 in its header and footer.
- R9: When only the block above is free, the result is one free block at the freed header whose size is the sum of the two sizes.
- R10: When only the block below is free, the result is one free block that starts at that block's header and whose size is the sum of the two sizes.
- R11: When both neighbours are free, the result is one free block that starts at the lower neighbour's header and whose size is the sum of all three sizes.
- R12: Freeing a pointer whose header has bit 0 clear answers rsp_ok = 0 and writes nothing.
- R13: Every accepted command produces exactly one rsp_valid pulse, one cycle long. cmd_ready is low while a command is in progress and during the response cycle. Responses to free commands carry rsp_ptr = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | A command is offered |
| cmd_ready | output | 1 | The engine can accept a command |
| cmd_op | input | 1 | 0 = allocate, 1 = free |
| cmd_size | input | ADDR_W | Requested payload words for an allocate |
| cmd_ptr | input | ADDR_W | Payload pointer for a free |
| rsp_valid | output | 1 | Response pulse |
| rsp_ok | output | 1 | Command succeeded |
| rsp_ptr | output | ADDR_W | Payload pointer, or 0 |
| mem_en | output | 1 | RAM access strobe |
| mem_we | output | 1 | RAM write when high, read when low |
| mem_addr | output | ADDR_W | RAM word address |
| mem_wdata | output | ADDR_W | RAM write data |
| mem_rdata | input | ADDR_W | RAM read data, one cycle after a read |

## Verification
The bench first sweeps every request size from 0 up to past the heap size against a fresh heap. Each size is followed by a free, so this one pass tells apart the three outcomes of the size check: rejection, a cut block and a whole-block grant. The free also shows whether a leftover is rejoined on the next free. A scripted sequence then fills the heap until a block is handed out without a cut and a request fails at the upper sentinel. It then frees blocks in an order that makes each of the four joining cases happen once, so a wrong neighbour read or a wrong start address shows up as a different tag word. A final pattern leaves a free hole below a larger free region and checks that the search stops at the first fit. The same pattern also cuts a block whose leftover is exactly the threshold.

// File: rtl/heap_alloc_pkg.sv
package heap_alloc_pkg;

   typedef enum logic [2:0] {
      S_IDLE,
      S_A_RD,
      S_A_CHK,
      S_F_RH,
      S_F_RP,
      S_F_RN,
      S_F_MG,
      S_WR
   } heap_state_e;

   localparam logic OP_ALLOC = 1'b0;
   localparam logic OP_FREE  = 1'b1;

endpackage

// File: rtl/heap_req_size.sv
module heap_req_size #(
   parameter int ADDR_W     = 12,
   parameter int HEAP_WORDS = 4096
) (
   input  logic [ADDR_W-1:0] req,
   output logic [ADDR_W-1:0] need,
   output logic              fits_heap
);
   localparam int W2 = ADDR_W + 2;
   localparam logic [W2-1:0] MAX_BLK = W2'(HEAP_WORDS - 2);

   logic [W2-1:0] even_w;
   logic [W2-1:0] full_w;

   assign even_w    = ({2'b00, req} + W2'(1)) & ~W2'(1);
   assign full_w    = even_w + W2'(2);
   assign fits_heap = (req != '0) && (full_w <= MAX_BLK);
   assign need      = full_w[ADDR_W-1:0];
endmodule

// File: rtl/heap_fit_calc.sv
module heap_fit_calc #(
   parameter int ADDR_W    = 12,
   parameter int MIN_SPLIT = 4
) (
   input  logic [ADDR_W-1:0]            blk_a,
   input  logic [ADDR_W-1:0]            blk_w,
   input  logic [ADDR_W-1:0]            need,
   output logic                         take,
   output logic                         at_end,
   output logic [ADDR_W-1:0]            adv,
   output logic [3:0][ADDR_W-1:0]       wa,
   output logic [3:0][ADDR_W-1:0]       wd,
   output logic [1:0]                   last
);
   localparam logic [ADDR_W-1:0] SPLIT_LIM = ADDR_W'(MIN_SPLIT);
   localparam logic [ADDR_W-1:0] ONE_A     = ADDR_W'(1);

   function automatic logic [ADDR_W-1:0] tag(input logic [ADDR_W-1:0] sz, input logic used);
      return {sz[ADDR_W-1:1], used};
   endfunction

   logic [ADDR_W-1:0] blk_size;
   logic [ADDR_W-1:0] rem;
   logic              cut;

   assign blk_size = {blk_w[ADDR_W-1:1], 1'b0};
   assign adv      = blk_size;
   assign at_end   = (blk_size == '0);
   assign take     = !blk_w[0] && !at_end && (blk_size >= need);
   assign rem      = blk_size - need;
   assign cut      = (rem >= SPLIT_LIM);

   always_comb begin
      wa = '0;
      wd = '0;
      if (cut) begin
         wa[0] = blk_a;
         wa[1] = blk_a + need - ONE_A;
         wa[2] = blk_a + need;
         wa[3] = blk_a + blk_size - ONE_A;
         wd[0] = tag(need, 1'b1);
         wd[1] = tag(need, 1'b1);
         wd[2] = tag(rem, 1'b0);
         wd[3] = tag(rem, 1'b0);
         last  = 2'd3;
      end else begin
         wa[0] = blk_a;
         wa[1] = blk_a + blk_size - ONE_A;
         wd[0] = tag(blk_size, 1'b1);
         wd[1] = tag(blk_size, 1'b1);
         last  = 2'd1;
      end
   end
endmodule

// File: rtl/heap_merge_calc.sv
module heap_merge_calc #(
   parameter int ADDR_W = 12
) (
   input  logic [ADDR_W-1:0]      hdr_a,
   input  logic [ADDR_W-1:0]      own_size,
   input  logic [ADDR_W-1:0]      below_w,
   input  logic [ADDR_W-1:0]      above_w,
   output logic [1:0][ADDR_W-1:0] wa,
   output logic [1:0][ADDR_W-1:0] wd
);
   localparam logic [ADDR_W-1:0] ONE_A = ADDR_W'(1);

   logic [ADDR_W-1:0] m_below;
   logic [ADDR_W-1:0] m_above;
   logic [ADDR_W-1:0] start;
   logic [ADDR_W-1:0] total;
   logic              below_free;
   logic              above_free;

   assign below_free = !below_w[0];
   assign above_free = !above_w[0];
   assign m_below    = below_free ? {below_w[ADDR_W-1:1], 1'b0} : '0;
   assign m_above    = above_free ? {above_w[ADDR_W-1:1], 1'b0} : '0;
   assign start      = hdr_a - m_below;
   assign total      = own_size + m_below + m_above;

   assign wa[0] = start;
   assign wa[1] = start + total - ONE_A;
   assign wd[0] = total;
   assign wd[1] = total;
endmodule

// File: rtl/heap_alloc_top.sv
module heap_alloc_top
   import heap_alloc_pkg::*;
#(
   parameter int ADDR_W     = 12,
   parameter int HEAP_WORDS = 4096,
   parameter int MIN_SPLIT  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic              cmd_op,
   input  logic [ADDR_W-1:0] cmd_size,
   input  logic [ADDR_W-1:0] cmd_ptr,
   output logic              rsp_valid,
   output logic              rsp_ok,
   output logic [ADDR_W-1:0] rsp_ptr,
   output logic              mem_en,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [ADDR_W-1:0] mem_wdata,
   input  logic [ADDR_W-1:0] mem_rdata
);
   localparam logic [ADDR_W-1:0] ONE_A     = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] TOP_A     = ADDR_W'(HEAP_WORDS - 1);
   localparam logic [ADDR_W-1:0] FIRST_SZ  = ADDR_W'(HEAP_WORDS - 2);
   localparam logic [ADDR_W-1:0] SENTINEL  = ADDR_W'(1);

   generate
      if ((HEAP_WORDS % 2) != 0 || HEAP_WORDS < 8 || HEAP_WORDS > (1 << ADDR_W)) begin : g_bad_heap
         $error("heap_alloc_top: HEAP_WORDS must be even, at least 8 and addressable by ADDR_W");
      end
      if (MIN_SPLIT < 4 || (MIN_SPLIT % 2) != 0) begin : g_bad_split
         $error("heap_alloc_top: MIN_SPLIT must be even and at least 4");
      end
   endgenerate

   heap_state_e                state;
   logic [ADDR_W-1:0]          cur;
   logic [ADDR_W-1:0]          need_r;
   logic [ADDR_W-1:0]          hdr_a;
   logic [ADDR_W-1:0]          hdr_w;
   logic [ADDR_W-1:0]          below_w;
   logic [3:0][ADDR_W-1:0]     wr_a;
   logic [3:0][ADDR_W-1:0]     wr_d;
   logic [1:0]                 wr_last;
   logic [1:0]                 wr_idx;
   logic                       resp_due;
   logic                       ok_due;
   logic [ADDR_W-1:0]          ptr_due;

   logic [ADDR_W-1:0]          req_need;
   logic                       req_ok;
   logic                       fit_take;
   logic                       fit_end;
   logic [ADDR_W-1:0]          fit_adv;
   logic [3:0][ADDR_W-1:0]     fit_wa;
   logic [3:0][ADDR_W-1:0]     fit_wd;
   logic [1:0]                 fit_last;
   logic [1:0][ADDR_W-1:0]     mg_wa;
   logic [1:0][ADDR_W-1:0]     mg_wd;
   logic [ADDR_W-1:0]          hdr_size;

   assign hdr_size  = {hdr_w[ADDR_W-1:1], 1'b0};
   assign cmd_ready = (state == S_IDLE) && !rsp_valid;

   heap_req_size #(.ADDR_W(ADDR_W), .HEAP_WORDS(HEAP_WORDS)) u_req (
      .req       (cmd_size),
      .need      (req_need),
      .fits_heap (req_ok)
   );

   heap_fit_calc #(.ADDR_W(ADDR_W), .MIN_SPLIT(MIN_SPLIT)) u_fit (
      .blk_a  (cur),
      .blk_w  (mem_rdata),
      .need   (need_r),
      .take   (fit_take),
      .at_end (fit_end),
      .adv    (fit_adv),
      .wa     (fit_wa),
      .wd     (fit_wd),
      .last   (fit_last)
   );

   heap_merge_calc #(.ADDR_W(ADDR_W)) u_merge (
      .hdr_a    (hdr_a),
      .own_size (hdr_size),
      .below_w  (below_w),
      .above_w  (mem_rdata),
      .wa       (mg_wa),
      .wd       (mg_wd)
   );

   always_comb begin
      mem_en    = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = cur;
      mem_wdata = wr_d[wr_idx];
      case (state)
         S_A_RD: begin mem_en = 1'b1; mem_addr = cur; end
         S_F_RH: begin mem_en = 1'b1; mem_addr = hdr_a; end
         S_F_RP: begin mem_en = 1'b1; mem_addr = hdr_a - ONE_A; end
         S_F_RN: begin mem_en = 1'b1; mem_addr = hdr_a + hdr_size; end
         S_WR:   begin mem_en = 1'b1; mem_we = 1'b1; mem_addr = wr_a[wr_idx]; end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= S_WR;
         cur       <= ONE_A;
         need_r    <= '0;
         hdr_a     <= '0;
         hdr_w     <= '0;
         below_w   <= '0;
         wr_a      <= {TOP_A, FIRST_SZ, ONE_A, ADDR_W'(0)};
         wr_d      <= {SENTINEL, FIRST_SZ, FIRST_SZ, SENTINEL};
         wr_last   <= 2'd3;
         wr_idx    <= 2'd0;
         resp_due  <= 1'b0;
         ok_due    <= 1'b0;
         ptr_due   <= '0;
         rsp_valid <= 1'b0;
         rsp_ok    <= 1'b0;
         rsp_ptr   <= '0;
      end else begin
         rsp_valid <= 1'b0;
         case (state)
            S_IDLE: begin
               if (cmd_valid && cmd_ready) begin
                  if (cmd_op == OP_ALLOC) begin
                     need_r <= req_need;
                     cur    <= ONE_A;
                     if (req_ok) begin
                        state <= S_A_RD;
                     end else begin
                        rsp_valid <= 1'b1;
                        rsp_ok    <= 1'b0;
                        rsp_ptr   <= '0;
                     end
                  end else begin
                     hdr_a <= cmd_ptr - ONE_A;
                     state <= S_F_RH;
                  end
               end
            end
            S_A_RD: state <= S_A_CHK;
            S_A_CHK: begin
               if (fit_end) begin
                  rsp_valid <= 1'b1;
                  rsp_ok    <= 1'b0;
                  rsp_ptr   <= '0;
                  state     <= S_IDLE;
               end else if (fit_take) begin
                  wr_a     <= fit_wa;
                  wr_d     <= fit_wd;
                  wr_last  <= fit_last;
                  wr_idx   <= 2'd0;
                  resp_due <= 1'b1;
                  ok_due   <= 1'b1;
                  ptr_due  <= cur + ONE_A;
                  state    <= S_WR;
               end else begin
                  cur   <= cur + fit_adv;
                  state <= S_A_RD;
               end
            end
            S_F_RH: state <= S_F_RP;
            S_F_RP: begin
               hdr_w <= mem_rdata;
               state <= S_F_RN;
            end
            S_F_RN: begin
               below_w <= mem_rdata;
               state   <= S_F_MG;
            end
            S_F_MG: begin
               if (!hdr_w[0]) begin
                  rsp_valid <= 1'b1;
                  rsp_ok    <= 1'b0;
                  rsp_ptr   <= '0;
                  state     <= S_IDLE;
               end else begin
                  wr_a[1:0] <= mg_wa;
                  wr_d[1:0] <= mg_wd;
                  wr_last   <= 2'd1;
                  wr_idx    <= 2'd0;
                  resp_due  <= 1'b1;
                  ok_due    <= 1'b1;
                  ptr_due   <= '0;
                  state     <= S_WR;
               end
            end
            S_WR: begin
               if (wr_idx == wr_last) begin
                  state    <= S_IDLE;
                  resp_due <= 1'b0;
                  if (resp_due) begin
                     rsp_valid <= 1'b1;
                     rsp_ok    <= ok_due;
                     rsp_ptr   <= ptr_due;
                  end
               end else begin
                  wr_idx <= wr_idx + 2'd1;
               end
            end
            default: state <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/heap_alloc_chk.sv
module heap_alloc_chk #(
   parameter int ADDR_W     = 12,
   parameter int HEAP_WORDS = 4096
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_valid,
   input logic              cmd_ready,
   input logic              cmd_op,
   input logic              rsp_valid,
   input logic              rsp_ok,
   input logic [ADDR_W-1:0] rsp_ptr,
   input logic              mem_en,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr
);
   localparam logic [ADDR_W:0] LIM = (ADDR_W+1)'(HEAP_WORDS);

   logic       last_free;
   logic       armed;
   logic [3:0] wr_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_free <= 1'b0;
         armed     <= 1'b0;
         wr_cnt    <= '0;
      end else if (cmd_valid && cmd_ready) begin
         last_free <= cmd_op;
         armed     <= 1'b1;
         wr_cnt    <= '0;
      end else if (mem_en && mem_we && wr_cnt != 4'hF) begin
         wr_cnt <= wr_cnt + 4'd1;
      end
   end

   a_r1_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
      mem_en |-> ({1'b0, mem_addr} < LIM));

   a_r5_alloc_writes: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_ok && !last_free) |-> (wr_cnt == 4'd2 || wr_cnt == 4'd4));

   a_r6_ptr_range: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_ok && !last_free) |->
         (rsp_ptr >= ADDR_W'(2) && {1'b0, rsp_ptr} < LIM - (ADDR_W+1)'(1)));

   a_r7_fail_null: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ok) |-> (rsp_ptr == '0));

   // Covers R7 and R12: a refused command leaves the RAM untouched.
   a_r7_fail_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ok) |-> (wr_cnt == 4'd0));

   // Covers R8 to R11: every join case costs exactly two writes.
   a_r8_free_writes: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_ok && last_free) |-> (wr_cnt == 4'd2));

   a_r13_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   a_r13_busy: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (!cmd_ready && armed));

   a_r13_free_ptr: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && last_free) |-> (rsp_ptr == '0));

   a_r2_write_enable: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> mem_en);
endmodule

bind heap_alloc_top heap_alloc_chk #(.ADDR_W(ADDR_W), .HEAP_WORDS(HEAP_WORDS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_valid (cmd_valid),
   .cmd_ready (cmd_ready),
   .cmd_op    (cmd_op),
   .rsp_valid (rsp_valid),
   .rsp_ok    (rsp_ok),
   .rsp_ptr   (rsp_ptr),
   .mem_en    (mem_en),
   .mem_we    (mem_we),
   .mem_addr  (mem_addr)
);

// File: tb/heap_alloc_top_tb_top.sv
`timescale 1ns/1ps
module heap_alloc_top_tb_top;
   localparam int TA = 6;
   localparam int TH = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic          cmd_ready;
   logic          cmd_op = 1'b0;
   logic [TA-1:0] cmd_size = '0;
   logic [TA-1:0] cmd_ptr = '0;
   logic          rsp_valid;
   logic          rsp_ok;
   logic [TA-1:0] rsp_ptr;
   logic          mem_en;
   logic          mem_we;
   logic [TA-1:0] mem_addr;
   logic [TA-1:0] mem_wdata;
   logic [TA-1:0] mem_rdata;
   logic [TA-1:0] ram [64];

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #10 clk = ~clk;

   always_ff @(posedge clk) begin
      if (mem_en) begin
         if (mem_we) ram[mem_addr] <= mem_wdata;
         mem_rdata <= ram[mem_addr];
      end
   end

   heap_alloc_top #(.ADDR_W(TA), .HEAP_WORDS(TH), .MIN_SPLIT(4)) dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_op(cmd_op), .cmd_size(cmd_size), .cmd_ptr(cmd_ptr),
      .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_ptr(rsp_ptr),
      .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic run_cmd(input logic op, input int size, input int ptr,
                          output int ok, output int rptr);
      @(negedge clk);
      while (!cmd_ready) @(negedge clk);
      cmd_valid = 1'b1;
      cmd_op    = op;
      cmd_size  = TA'(size);
      cmd_ptr   = TA'(ptr);
      @(negedge clk);
      cmd_valid = 1'b0;
      while (!rsp_valid) @(negedge clk);
      ok   = int'(rsp_ok);
      rptr = int'(rsp_ptr);
   endtask

   task automatic alloc_chk(input string tag, input int size, input int exp_ok, input int exp_ptr);
      int ok, p;
      run_cmd(1'b0, size, 0, ok, p);
      check({tag, " ok"}, ok, exp_ok);
      check({tag, " ptr"}, p, exp_ptr);
   endtask

   task automatic free_chk(input string tag, input int ptr, input int exp_ok);
      int ok, p;
      run_cmd(1'b1, 0, ptr, ok, p);
      check({tag, " ok"}, ok, exp_ok);
      check({tag, " ptr"}, p, 0);
   endtask

   task automatic ram_chk(input string tag, input int addr, input int exp);
      check(tag, int'(ram[addr]), exp);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 64; i++) ram[i] = '0;
      repeat (3) @(negedge clk);
      check("R1 ready low in reset", int'(cmd_ready), 0);
      check("R13 no response in reset", int'(rsp_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 ready low during setup", int'(cmd_ready), 0);
      while (!cmd_ready) @(negedge clk);
      ram_chk("R1 lower sentinel", 0, 1);
      ram_chk("R1 first header", 1, TH - 2);
      ram_chk("R1 first footer", TH - 2, TH - 2);
      ram_chk("R1 upper sentinel", TH - 1, 1);

      // R3 R5 R6 sweep of every request size against an empty heap
      for (int s = 0; s < 34; s++) begin
         int need, okx, rem;
         need = ((s + 1) & ~1) + 2;
         okx  = (s != 0 && need <= TH - 2) ? 1 : 0;
         rem  = TH - 2 - need;
         alloc_chk($sformatf("R3 sweep s=%0d", s), s, okx, okx ? 2 : 0);
         if (okx) begin
            if (rem >= 4) begin
               ram_chk($sformatf("R5 cut header s=%0d", s), 1, need + 1);
               ram_chk($sformatf("R5 cut footer s=%0d", s), need, need + 1);
               ram_chk($sformatf("R5 leftover header s=%0d", s), 1 + need, rem);
               ram_chk($sformatf("R5 leftover footer s=%0d", s), TH - 2, rem);
            end else begin
               ram_chk($sformatf("R5 whole header s=%0d", s), 1, TH - 1);
               ram_chk($sformatf("R5 whole footer s=%0d", s), TH - 2, TH - 1);
            end
            free_chk($sformatf("R9 sweep free s=%0d", s), 2, 1);
            ram_chk($sformatf("R9 sweep rejoin s=%0d", s), 1, TH - 2);
            ram_chk($sformatf("R9 sweep footer s=%0d", s), TH - 2, TH - 2);
         end else begin
            ram_chk($sformatf("R7 untouched s=%0d", s), 1, TH - 2);
         end
      end

      // Fill the heap
      alloc_chk("R6 A", 2, 1, 2);
      alloc_chk("R4 B", 4, 1, 6);
      ram_chk("R2 B header", 5, 7);
      ram_chk("R2 B footer", 10, 7);
      alloc_chk("R4 C", 1, 1, 12);
      alloc_chk("R3 D rounded", 3, 1, 16);
      ram_chk("R3 D header", 15, 7);
      alloc_chk("R5 E whole", 8, 1, 22);
      ram_chk("R5 E header", 21, 11);
      ram_chk("R5 E footer", 30, 11);
      alloc_chk("R7 full", 1, 0, 0);
      ram_chk("R7 A kept", 1, 5);
      ram_chk("R7 sentinel kept", 31, 1);

      free_chk("R8 B", 6, 1);
      ram_chk("R8 B header", 5, 6);
      ram_chk("R8 B footer", 10, 6);
      free_chk("R12 double", 6, 0);
      ram_chk("R12 B header kept", 5, 6);
      alloc_chk("R4 too big for hole", 5, 0, 0);
      alloc_chk("R5 no cut below threshold", 1, 1, 6);
      ram_chk("R5 hole header", 5, 7);
      ram_chk("R5 hole footer", 10, 7);
      free_chk("R8 B again", 6, 1);
      ram_chk("R8 B again header", 5, 6);

      free_chk("R10 C", 12, 1);
      ram_chk("R10 header", 5, 10);
      ram_chk("R10 footer", 14, 10);
      free_chk("R8 E", 22, 1);
      ram_chk("R8 E header", 21, 10);
      ram_chk("R8 E footer", 30, 10);
      free_chk("R9 A", 2, 1);
      ram_chk("R9 header", 1, 14);
      ram_chk("R9 footer", 14, 14);
      free_chk("R11 D", 16, 1);
      ram_chk("R11 header", 1, 30);
      ram_chk("R11 footer", 30, 30);

      // R4 first fit over a later, larger region; leftover exactly 4
      alloc_chk("R4 X", 6, 1, 2);
      alloc_chk("R4 Y", 2, 1, 10);
      alloc_chk("R4 Z", 2, 1, 14);
      ram_chk("R4 tail header", 17, 14);
      free_chk("R8 X", 2, 1);
      ram_chk("R8 X header", 1, 8);
      alloc_chk("R4 first fit", 2, 1, 2);
      ram_chk("R5 threshold cut header", 1, 5);
      ram_chk("R5 threshold leftover", 5, 4);
      ram_chk("R5 threshold leftover footer", 8, 4);
      ram_chk("R4 tail untouched", 17, 14);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule